// File: doc/BRIEF.md
# Buffer Configuration Command Port

This block is the host-side command port of a sequential-access memory. It lets a host reach the small set of registers that configure the sequential pointer unit. The host drives a command select, a 3-bit register address, a read/write line, an output enable and a 16-bit data bus. All of these are sampled on a system clock, and a write takes effect on the clock edge at which it is presented. The port holds two start addresses, two end addresses and a control word, and passes all of them to the pointer unit. It returns the two end-of-buffer flags from the pointer unit through a read-only flag register. It sends a one-cycle clear pulse for a flag when a zero is written into that flag's bit of the control word.

The command select and the memory array's chip enable are both active low, and they must never be asserted together. When both are low, the port raises an error output. It then blocks the register access and withholds the array access grant. When only the chip enable is low, the array access grant is raised.

Register map, with the address on `regAddr[2:0]`:

| Address | Register |
|---|---|
| 000 | start 1 |
| 001 | end 1 |
| 010 | start 2 |
| 011 | end 2 |
| 100 | flags, read-only |
| 101 | control |
| 110, 111 | reserved |

Top module: `host_cmd_port`

## Requirements
- R1: The asynchronous active-low reset `rstN` clears the start, end and control registers to zero and drives `clrFlag` to 00. This holds both at power-up and when reset is asserted in mid-run.
- R2: A register write happens at a rising clock edge when `cmdSelN`=0, `arrayCeN`=1 and `rwN`=0. At address 000, 001, 010 or 011 it loads `wrData[11:0]` into start 1, end 1, start 2 or end 2 respectively, and `wrData[15:12]` is ignored. Start 1 and start 2 appear on `startPtr[11:0]` and `startPtr[23:12]`; end 1 and end 2 appear on `endPtr[11:0]` and `endPtr[23:12]`.
- R3: A read of address 000 to 011 returns the 12-bit register in `rdData[11:0]`, with `rdData[15:12]`=0.
- R4: A read of address 100 returns `flagIn[1:0]` in `rdData[1:0]` and zero in the other bits. Writes to 100 change no register.
- R5: A write to address 101 stores `wrData[12:0]` into the control word shown on `ctrlWord`. A read of 101 returns that word with `rdData[15:13]`=0.
- R6: A write to 101 with `wrData[0]`=0 raises `clrFlag[0]` for exactly the one cycle after the write edge. `wrData[1]`=0 does the same for `clrFlag[1]`. A bit written as 1 raises no pulse, and writes to other addresses raise none.
- R7: Writes to addresses 110 and 111 change no register. Reads of 110 and 111 return zero.
- R8: While `cmdSelN`=0 and `arrayCeN`=0, `conflictErr` is 1 and `arrayGrant` is 0. In that state a write changes no register and raises no clear pulse, and `rdValid` is 0.
- R9: `rdValid` is 1 exactly when `cmdSelN`=0, `arrayCeN`=1, `rwN`=1 and `oeN`=0. Whenever `rdValid` is 0, `rdData` is zero.
- R10: `arrayGrant` is 1 exactly when `arrayCeN`=0 and `cmdSelN`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdSelN | input | 1 | Register command select, active low |
| arrayCeN | input | 1 | Array chip enable, active low |
| rwN | input | 1 | 1 = read, 0 = write |
| oeN | input | 1 | Read output enable, active low |
| regAddr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| flagIn | input | 2 | End-of-buffer flag status from the pointer unit |
| rdData | output | 16 | Read data, zero when not valid |
| rdValid | output | 1 | Read data valid |
| conflictErr | output | 1 | Command select and chip enable are both low |
| arrayGrant | output | 1 | Array access permitted |
| clrFlag | output | 2 | One-cycle clear pulse per end flag |
| startPtr | output | 24 | Start addresses 2 and 1, packed |
| endPtr | output | 24 | End addresses 2 and 1, packed |
| ctrlWord | output | 13 | Control register |

## Verification
The bench writes six data patterns to every address, including all-zero, all-one and the patterns that clear each flag alone. After each write it reads back the whole map and checks it against a bench-side model. This catches a design that decodes an address onto the wrong register, lets upper data bits leak into a 12-bit register, accepts writes to the flag or reserved addresses, or inverts the sense of the clear bits. The bench also checks that each clear pulse drops after one cycle, so a level-held or two-cycle pulse is caught. It walks all sixteen combinations of the four control lines to catch a read-valid or grant decode that ignores one of them. It also drives a write during a select/enable conflict, which exposes a design that lets the write through. A mid-run reset confirms that every register returns to zero.

// File: rtl/host_cmd_pkg.sv
package host_cmd_pkg;
  localparam int ADDR_W  = 3;
  localparam int BUF_CNT = 2;

  localparam logic [ADDR_W-1:0] A_FLAG = 3'b100;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'b101;

  typedef struct packed {
    logic [BUF_CNT-1:0] wrStart;
    logic [BUF_CNT-1:0] wrEnd;
    logic               wrCtrl;
    logic               rdEn;
    logic               conflict;
  } cmdStrobe_t;
endpackage

// File: rtl/host_cmd_ctrl.sv
module host_cmd_ctrl
  import host_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSelN,
  input  logic              arrayCeN,
  input  logic              rwN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] regAddr,
  output cmdStrobe_t        strobe,
  output logic              rdValid,
  output logic              conflictErr,
  output logic              arrayGrant
);
  logic regAccess;
  logic wrEn;

  assign regAccess = !cmdSelN && arrayCeN;
  assign wrEn      = regAccess && !rwN;

  always_comb begin
    strobe = '0;
    for (int ch = 0; ch < BUF_CNT; ch++) begin
      if (wrEn && !regAddr[2] && (regAddr[1] == ch[0])) begin
        strobe.wrStart[ch] = !regAddr[0];
        strobe.wrEnd[ch]   = regAddr[0];
      end
    end
    strobe.wrCtrl   = wrEn && (regAddr == A_CTRL);
    strobe.rdEn     = regAccess && rwN && !oeN;
    strobe.conflict = !cmdSelN && !arrayCeN;
  end

  assign rdValid     = strobe.rdEn;
  assign conflictErr = strobe.conflict;
  assign arrayGrant  = !arrayCeN && cmdSelN;

  // R10: grant and conflict error are never high together
  p_grant_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(arrayGrant && conflictErr));

  // R8: a conflict raises no register strobe
  p_conflict_no_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    conflictErr |-> (strobe.wrStart == '0 && strobe.wrEnd == '0 && !strobe.wrCtrl && !rdValid));

  // R2: at most one register write strobe in a cycle
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrStart, strobe.wrEnd, strobe.wrCtrl}));
endmodule

// File: rtl/host_cmd_regs.sv
module host_cmd_regs
  import host_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 12,
  parameter int CTRL_W = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cmdStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [BUF_CNT-1:0]       flagIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [BUF_CNT-1:0]       clrFlag,
  output logic [BUF_CNT*PTR_W-1:0] startBus,
  output logic [BUF_CNT*PTR_W-1:0] endBus,
  output logic [CTRL_W-1:0]        ctrlQ
);
  for (genvar g = 0; g < BUF_CNT; g++) begin : g_buf
    logic [PTR_W-1:0] startQ;
    logic [PTR_W-1:0] endQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startQ <= '0;
        endQ   <= '0;
      end else begin
        if (strobe.wrStart[g]) startQ <= wrData[PTR_W-1:0];
        if (strobe.wrEnd[g])   endQ   <= wrData[PTR_W-1:0];
      end
    end

    assign startBus[g*PTR_W +: PTR_W] = startQ;
    assign endBus[g*PTR_W +: PTR_W]   = endQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      clrFlag <= '0;
    end else begin
      if (strobe.wrCtrl) ctrlQ <= wrData[CTRL_W-1:0];
      clrFlag <= strobe.wrCtrl ? ~wrData[BUF_CNT-1:0] : '0;
    end
  end

  logic chSel;
  assign chSel = regAddr[1];

  always_comb begin
    rdData = '0;
    if (strobe.rdEn) begin
      if (!regAddr[2]) begin
        rdData[PTR_W-1:0] = regAddr[0] ? endBus[chSel*PTR_W +: PTR_W]
                                       : startBus[chSel*PTR_W +: PTR_W];
      end else if (regAddr == A_FLAG) begin
        rdData[BUF_CNT-1:0] = flagIn;
      end else if (regAddr == A_CTRL) begin
        rdData[CTRL_W-1:0] = ctrlQ;
      end
    end
  end

  // R8: a conflict cycle leaves every register untouched
  p_conflict_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.conflict |=> ($stable(startBus) && $stable(endBus) && $stable(ctrlQ)));

  // R6: a clear pulse only follows a control write
  p_clr_after_ctrl_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag != '0) |-> $past(strobe.wrCtrl));

  // R9: idle read bus is zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |-> (rdData == '0));

  // R3: pointer reads have clear upper bits
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !regAddr[2]) |-> (rdData[DATA_W-1:PTR_W] == '0));

  // R7: reserved reads return zero
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && regAddr[2] && regAddr[1]) |-> (rdData == '0));
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
  import host_cmd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 12,
  parameter int CTRL_W = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdSelN,
  input  logic                     arrayCeN,
  input  logic                     rwN,
  input  logic                     oeN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [BUF_CNT-1:0]       flagIn,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid,
  output logic                     conflictErr,
  output logic                     arrayGrant,
  output logic [BUF_CNT-1:0]       clrFlag,
  output logic [BUF_CNT*PTR_W-1:0] startPtr,
  output logic [BUF_CNT*PTR_W-1:0] endPtr,
  output logic [CTRL_W-1:0]        ctrlWord
);
  cmdStrobe_t strobe;

  host_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdSelN    (cmdSelN),
    .arrayCeN   (arrayCeN),
    .rwN        (rwN),
    .oeN        (oeN),
    .regAddr    (regAddr),
    .strobe     (strobe),
    .rdValid    (rdValid),
    .conflictErr(conflictErr),
    .arrayGrant (arrayGrant)
  );

  host_cmd_regs #(
    .DATA_W(DATA_W),
    .PTR_W (PTR_W),
    .CTRL_W(CTRL_W)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regAddr (regAddr),
    .wrData  (wrData),
    .flagIn  (flagIn),
    .rdData  (rdData),
    .clrFlag (clrFlag),
    .startBus(startPtr),
    .endBus  (endPtr),
    .ctrlQ   (ctrlWord)
  );
endmodule

// File: tb/tb_host_cmd_port.sv
module tb_host_cmd_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdSelN = 1'b1;
  logic        arrayCeN = 1'b1;
  logic        rwN = 1'b1;
  logic        oeN = 1'b1;
  logic [2:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  flagIn = '0;
  logic [15:0] rdData;
  logic        rdValid, conflictErr, arrayGrant;
  logic [1:0]  clrFlag;
  logic [23:0] startPtr, endPtr;
  logic [12:0] ctrlWord;

  int checks = 0;
  int errors = 0;
  logic [11:0] mStart [2];
  logic [11:0] mEnd [2];
  logic [12:0] mCtrl;

  host_cmd_port dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {4'b0, mStart[0]};
      3'd1: return {4'b0, mEnd[0]};
      3'd2: return {4'b0, mStart[1]};
      3'd3: return {4'b0, mEnd[1]};
      3'd4: return {14'b0, flagIn};
      3'd5: return {3'b0, mCtrl};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic checkOutputs(input string tag);
    check({tag, " R2 startPtr"}, {8'b0, startPtr}, {8'b0, mStart[1], mStart[0]});
    check({tag, " R2 endPtr"}, {8'b0, endPtr}, {8'b0, mEnd[1], mEnd[0]});
    check({tag, " R5 ctrlWord"}, {19'b0, ctrlWord}, {19'b0, mCtrl});
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      cmdSelN = 1'b0; rwN = 1'b1; oeN = 1'b0; regAddr = 3'(a);
      #1;
      check({tag, " R3 R4 R5 R7 read"}, {16'b0, rdData}, {16'b0, expRead(3'(a))});
      check({tag, " R9 rdValid on"}, {31'b0, rdValid}, 32'd1);
      cmdSelN = 1'b1; oeN = 1'b1;
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    logic [1:0] expClr;
    @(negedge clk);
    cmdSelN = 1'b0; rwN = 1'b0; regAddr = a; wrData = d;
    @(posedge clk);
    case (a)
      3'd0: mStart[0] = d[11:0];
      3'd1: mEnd[0]   = d[11:0];
      3'd2: mStart[1] = d[11:0];
      3'd3: mEnd[1]   = d[11:0];
      3'd5: mCtrl     = d[12:0];
      default: ;
    endcase
    expClr = (a == 3'd5) ? ~d[1:0] : 2'b00;
    @(negedge clk);
    cmdSelN = 1'b1; rwN = 1'b1;
    check("R6 clear pulse", {30'b0, clrFlag}, {30'b0, expClr});
    checkOutputs("R2 R4 R7 after write");
    @(negedge clk);
    check("R6 pulse one cycle", {30'b0, clrFlag}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mStart[0] = '0; mStart[1] = '0; mEnd[0] = '0; mEnd[1] = '0; mCtrl = '0;
    repeat (3) @(negedge clk);
    checkOutputs("R1 reset");
    check("R1 reset clrFlag", {30'b0, clrFlag}, 32'd0);
    rstN = 1'b1;
    readAll("R1 after reset");

    // Sweep every address with several patterns
    for (int a = 0; a < 8; a++) begin
      for (int p = 0; p < 6; p++) begin
        logic [15:0] d;
        case (p)
          0: d = 16'h0000;
          1: d = 16'hFFFF;
          2: d = 16'h0001;
          3: d = 16'h0002;
          default: d = 16'(((a + 3) * 16'h3B5D) ^ (p * 16'h1F03));
        endcase
        flagIn = 2'(p + a);
        writeReg(3'(a), d);
        readAll("sweep");
      end
    end

    // R9 R10 R8: control line decode over all combinations, no edge crossed
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cmdSelN = c[0]; arrayCeN = c[1]; rwN = c[2]; oeN = c[3];
      regAddr = 3'd0;
      #1;
      check("R9 rdValid decode", {31'b0, rdValid},
            {31'b0, (!c[0] && c[1] && c[2] && !c[3])});
      check("R10 arrayGrant decode", {31'b0, arrayGrant}, {31'b0, (!c[1] && c[0])});
      check("R8 conflictErr decode", {31'b0, conflictErr}, {31'b0, (!c[0] && !c[1])});
      if (!rdValid) check("R9 rdData zero", {16'b0, rdData}, 32'd0);
      cmdSelN = 1'b1; arrayCeN = 1'b1; rwN = 1'b1; oeN = 1'b1;
    end

    // R8: write attempted during conflict
    for (int a = 0; a < 6; a++) begin
      @(negedge clk);
      cmdSelN = 1'b0; arrayCeN = 1'b0; rwN = 1'b0; regAddr = 3'(a); wrData = 16'h0ABC;
      @(negedge clk);
      check("R8 conflict flag", {31'b0, conflictErr}, 32'd1);
      check("R8 no clear pulse", {30'b0, clrFlag}, 32'd0);
      checkOutputs("R8 conflict hold");
      cmdSelN = 1'b1; arrayCeN = 1'b1; rwN = 1'b1;
    end
    readAll("R8 after conflict");

    // R1: mid-run reset
    writeReg(3'd1, 16'h0FED);
    writeReg(3'd5, 16'h1FFC);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    mStart[0] = '0; mStart[1] = '0; mEnd[0] = '0; mEnd[1] = '0; mCtrl = '0;
    checkOutputs("R1 midrun reset");
    check("R1 midrun clrFlag", {30'b0, clrFlag}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    readAll("R1 after midrun reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule